// File: doc/BRIEF.md
# Two-Bit Serial Check-Value Generator and Checker

This block computes a 2-bit check value over a fixed-length serial code word, one data bit per strobe. A `start` pulse clears the running value and opens a new word. After the final covered bit is taken in, the block raises a one-cycle completion pulse and holds the finished check value on its output. A transmitter reads that value and appends it to the word.

The same block also serves a receiver. The received check value is presented on `rx_check` together with the last data bit. The block compares it with the value it computed. If the two differ, it recomputes the whole word from a stored copy of the bits, this time with one designated status bit inverted. This covers the case where that status bit was sampled differently for the check computation than for the transmitted word. The verdict tells which of the two passes matched, or that neither did. The retry is evaluated from the stored bits in the same cycle as the last bit, so the verdict needs no retransmission and no extra latency.

Top module: `crc2_codec`

## Requirements
- R1: While reset is held and on the first cycle after it, `crc_out` is 2'b00 and `word_done`, `match_normal`, `match_flipped` and `error` are all 0.
- R2: A `start` pulse sets `crc_out` to 2'b00 on the next cycle and restarts the bit count. A `bit_valid` in the same cycle as `start` is ignored.
- R3: For each accepted bit d, with `crc_out[1]` = c1 and `crc_out[0]` = c0, the next cycle shows c1' = c0 ^ d and c0' = c0 ^ d ^ c1. Cycles without `bit_valid` leave `crc_out` unchanged.
- R4: The word covers exactly NBITS (default 65) accepted bits, indexed 0 upward in arrival order. `word_done` pulses high for exactly one cycle, in the cycle after the last bit is accepted. `crc_out` then holds the final value.
- R5: When no word is open (after reset, or after completion until the next `start`), `bit_valid` strobes are ignored. `crc_out` does not change and no `word_done` is produced.
- R6: While `word_done` is high, `match_normal` is 1 exactly when `rx_check`, sampled with the last bit, equals the computed value.
- R7: While `word_done` is high, `match_flipped` is 1 exactly when the normal pass failed and `rx_check` equals the value recomputed with bit FLIP_POS (default 64, the last bit) inverted.
- R8: While `word_done` is high, `error` is 1 exactly when neither pass matched, so exactly one of the three verdict outputs is 1. All three are 0 in every other cycle.
- R9: A `start` pulse in the middle of a word abandons it without any `word_done`. The next `word_done` comes only after NBITS bits following that `start`.
- R10: Inverting any single covered bit of a word changes the final check value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new word and clears the check value |
| bit_valid | input | 1 | Strobe: `bit_in` is the next data bit |
| bit_in | input | 1 | Serial data bit |
| rx_check | input | 2 | Received check value, sampled with the last bit |
| crc_out | output | 2 | Running / final check value (bit 1 = c1, bit 0 = c0) |
| word_done | output | 1 | One-cycle pulse after the last covered bit |
| match_normal | output | 1 | Received value matched the plain computation |
| match_flipped | output | 1 | Received value matched only with the status bit inverted |
| error | output | 1 | Neither pass matched |

## Verification
The assertions assume that `start` is never held for more than a pulse while a completion is pending. They also assume the environment sends no further bits into an open word after its final bit, since any such strobes are dropped. The bench therefore always opens a word with a single-cycle `start`. It sends exactly NBITS strobes, or fewer followed by a fresh `start` for the abort case. Any strobes outside a word are issued only deliberately, to show they are ignored. `rx_check` is held steady from before the last bit onward, so the value the block samples is the one the scoreboard predicted.

// File: rtl/crc2_pkg.sv
package crc2_pkg;

    typedef logic [1:0] chk_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic hit_plain;
        logic hit_retry;
        logic miss;
    } verdict_t;

    // One step of the 2-bit recurrence.
    function automatic chk_t crc2_step(input chk_t cur, input logic d);
        chk_t nxt;
        nxt[1] = cur[0] ^ d;
        nxt[0] = cur[0] ^ d ^ cur[1];
        return nxt;
    endfunction

endpackage

// File: rtl/crc2_seq.sv
module crc2_seq
    import crc2_pkg::*;
#(
    parameter int NBITS = 65
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic bit_valid,
    output logic accept,
    output logic last,
    output logic done
);
    localparam int CW = $clog2(NBITS);
    localparam logic [CW-1:0] LAST_IDX = CW'(NBITS - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;

    assign accept = !start && (phase == PH_RUN) && bit_valid;
    assign last   = accept && (cnt == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                phase <= PH_RUN;
                cnt   <= '0;
            end else if (accept) begin
                if (cnt == LAST_IDX) begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                    done  <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !start) |=> (phase == PH_IDLE && cnt == '0));

    // R9
    start_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == '0 && phase == PH_RUN && !done));

endmodule

// File: rtl/crc2_engine.sv
module crc2_engine
    import crc2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic din,
    output chk_t state
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= '0;
        end else if (en) begin
            state <= crc2_step(state, din);
        end
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(state));

    // R2
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (state == 2'b00));

endmodule

// File: rtl/crc2_shiftbuf.sv
module crc2_shiftbuf #(
    parameter int NBITS = 65
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [NBITS-1:0] word
);
    localparam int SW = NBITS - 1;

    logic [SW-1:0] held;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            held <= '0;
        end else if (en) begin
            held <= {held[SW-2:0], din};
        end
    end

    // Oldest bit ends at the top, the bit being presented at the bottom.
    assign word = {held, din};

    // R2
    buf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (held == '0));

endmodule

// File: rtl/crc2_retry.sv
module crc2_retry
    import crc2_pkg::*;
#(
    parameter int NBITS    = 65,
    parameter int FLIP_POS = 64
) (
    input  logic [NBITS-1:0] word,
    output chk_t             crc_flip
);
    always_comb begin
        chk_t acc;
        acc = '0;
        for (int i = 0; i < NBITS; i++) begin
            acc = crc2_step(acc, word[NBITS-1-i] ^ (i == FLIP_POS));
        end
        crc_flip = acc;
    end

    initial begin
        // R7
        flip_pos_range_chk: assert (FLIP_POS >= 0 && FLIP_POS < NBITS);
    end

endmodule

// File: rtl/crc2_codec.sv
module crc2_codec
    import crc2_pkg::*;
#(
    parameter int NBITS    = 65,
    parameter int FLIP_POS = NBITS - 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic [1:0] rx_check,
    output logic [1:0] crc_out,
    output logic       word_done,
    output logic       match_normal,
    output logic       match_flipped,
    output logic       error
);
    logic             accept;
    logic             last;
    chk_t             state;
    chk_t             plain_next;
    chk_t             flip_crc;
    logic [NBITS-1:0] word;
    verdict_t         verdict;

    crc2_seq #(.NBITS(NBITS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .bit_valid (bit_valid),
        .accept    (accept),
        .last      (last),
        .done      (word_done)
    );

    crc2_engine u_engine (
        .clk   (clk),
        .rst   (rst),
        .clr   (start),
        .en    (accept),
        .din   (bit_in),
        .state (state)
    );

    crc2_shiftbuf #(.NBITS(NBITS)) u_buf (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .en   (accept),
        .din  (bit_in),
        .word (word)
    );

    crc2_retry #(.NBITS(NBITS), .FLIP_POS(FLIP_POS)) u_retry (
        .word     (word),
        .crc_flip (flip_crc)
    );

    assign plain_next = crc2_step(state, bit_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= '0;
        end else if (last) begin
            verdict.hit_plain <= (plain_next == rx_check);
            verdict.hit_retry <= (plain_next != rx_check) && (flip_crc == rx_check);
            verdict.miss      <= (plain_next != rx_check) && (flip_crc != rx_check);
        end else begin
            verdict <= '0;
        end
    end

    assign crc_out       = state;
    assign match_normal  = verdict.hit_plain;
    assign match_flipped = verdict.hit_retry;
    assign error         = verdict.miss;

    // R8
    verdict_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        word_done |-> ($countones({match_normal, match_flipped, error}) == 1));

    // R8
    verdict_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !word_done |-> !(match_normal || match_flipped || error));

    // R2
    start_clr_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (crc_out == 2'b00 && !word_done));

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (word_done && !start) |=> $stable(crc_out));

endmodule

// File: tb/crc2_codec_bench.sv
`timescale 1ns/1ps
module crc2_codec_bench;
    localparam int NB   = 65;
    localparam int FLIP = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       bit_valid;
    logic       bit_in;
    logic [1:0] rx_check;
    logic [1:0] crc_out;
    logic       word_done;
    logic       match_normal;
    logic       match_flipped;
    logic       error;

    always #2.5 clk = ~clk;

    crc2_codec u_crc2_codec (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .bit_valid     (bit_valid),
        .bit_in        (bit_in),
        .rx_check      (rx_check),
        .crc_out       (crc_out),
        .word_done     (word_done),
        .match_normal  (match_normal),
        .match_flipped (match_flipped),
        .error         (error)
    );

    typedef struct packed {
        logic [1:0] crc;
        logic       mn;
        logic       mf;
        logic       er;
    } exp_t;

    exp_t sb[$];
    int   n_run  = 0;
    int   n_fail = 0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Reference recurrence over the first 'upto' bits, optional inversion of bit FLIP.
    function automatic logic [1:0] ref_crc(input logic [NB-1:0] w, input int upto, input bit flip);
        logic [1:0] c;
        logic       d;
        logic       n1;
        logic       n0;
        c = 2'b00;
        for (int n = 0; n < upto; n++) begin
            d  = w[n] ^ (flip && n == FLIP);
            n1 = c[0] ^ d;
            n0 = c[0] ^ d ^ c[1];
            c  = {n1, n0};
        end
        return c;
    endfunction

    task automatic send_word(input logic [NB-1:0] w, input logic [1:0] rx,
                             input int gap, input int abort_at, input bit run_chk);
        logic [1:0] pc;
        logic [1:0] pf;
        exp_t       e;
        // start pulse with a same-cycle strobe that must be ignored (R2)
        @(negedge clk);
        start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        start = 1'b0; bit_valid = 1'b0;
        chk("R2", crc_out, 2'b00);
        if (abort_at > 0) begin
            for (int n = 0; n < abort_at; n++) begin
                bit_valid = 1'b1; bit_in = ~w[n];
                @(negedge clk);
                bit_valid = 1'b0;
            end
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            // R9: aborted word cleared
            chk("R9", crc_out, 2'b00);
        end
        pc = ref_crc(w, NB, 1'b0);
        pf = ref_crc(w, NB, 1'b1);
        e.crc = pc;
        e.mn  = (rx == pc);
        e.mf  = (rx != pc) && (rx == pf);
        e.er  = (rx != pc) && (rx != pf);
        sb.push_back(e);
        rx_check = rx;
        for (int n = 0; n < NB; n++) begin
            bit_valid = 1'b1; bit_in = w[n];
            @(negedge clk);
            bit_valid = 1'b0;
            if (run_chk) chk("R3", crc_out, ref_crc(w, n + 1, 1'b0));
            repeat (gap) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // Monitor / scoreboard
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (word_done) begin
                    if (sb.size() == 0) begin
                        n_run++; n_fail++;
                        $display("FAIL R9 actual=unexpected word_done expected=none");
                    end else begin
                        e = sb.pop_front();
                        chk("R4", crc_out, e.crc);
                        chk("R6", match_normal, e.mn);
                        chk("R7", match_flipped, e.mf);
                        chk("R8", error, e.er);
                    end
                end else if (match_normal || match_flipped || error) begin
                    n_fail++;
                    $display("FAIL R8 actual=%0d expected=0",
                             {match_normal, match_flipped, error});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [NB-1:0] w1, w2, w3, w4, wk;
        logic [1:0]    p, f, bad;
        rst = 1'b1; start = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; rx_check = 2'b00;
        repeat (3) @(negedge clk);
        // R1
        chk("R1", {crc_out, word_done, match_normal, match_flipped, error}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {crc_out, word_done, match_normal, match_flipped, error}, 0);

        // R5: strobes before any start are ignored
        for (int i = 0; i < 4; i++) begin
            bit_valid = 1'b1; bit_in = 1'b1;
            @(negedge clk);
        end
        bit_valid = 1'b0;
        @(negedge clk);
        chk("R5", crc_out, 2'b00);

        w1 = {1'b1, 64'hA5C3_19F0_7E2D_4B86};
        w2 = {1'b0, 64'h0123_4567_89AB_CDEF};
        w3 = {1'b1, 64'hFFFF_0000_F0F0_3C3C};
        w4 = {1'b0, 64'h5A5A_C3C3_9669_1248};

        // R6 with per-bit R3 checks
        send_word(w1, ref_crc(w1, NB, 1'b0), 0, 0, 1'b1);

        // R5: strobes after completion ignored, final value held
        for (int i = 0; i < 5; i++) begin
            bit_valid = 1'b1; bit_in = i[0];
            @(negedge clk);
        end
        bit_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5", crc_out, ref_crc(w1, NB, 1'b0));

        // R7: received value matches only the retry pass
        send_word(w2, ref_crc(w2, NB, 1'b1), 0, 0, 1'b0);

        // R8: neither pass matches
        p = ref_crc(w3, NB, 1'b0);
        f = ref_crc(w3, NB, 1'b1);
        bad = 2'b00;
        for (int v = 0; v < 4; v++) begin
            if (2'(v) != p && 2'(v) != f) bad = 2'(v);
        end
        send_word(w3, bad, 0, 0, 1'b0);

        // Gaps between strobes (R3 hold) and plain match
        send_word(w4, ref_crc(w4, NB, 1'b0), 2, 0, 1'b1);

        // R9: abort after 20 bits, then a full word
        send_word(w2, ref_crc(w2, NB, 1'b0), 0, 20, 1'b0);
        // R9: abort after 64 bits (one short of completion)
        send_word(w3, ref_crc(w3, NB, 1'b1), 0, 64, 1'b0);

        // R10: single-bit inversions change the final value
        for (int k = 0; k < NB; k += 16) begin
            wk = w1 ^ (65'd1 << k);
            send_word(wk, ref_crc(w1, NB, 1'b0), 0, 0, 1'b0);
            chk("R10", (crc_out == ref_crc(w1, NB, 1'b0)) ? 1 : 0, 0);
        end

        repeat (4) @(negedge clk);
        chk("R4", sb.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule